// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block drives the inputs of a circuit under test during built-in self-test with pseudo-random vectors. The aim is to cause less switching on those inputs than a plain shift-register generator would. A 36-bit maximal-length linear feedback shift register supplies the major vectors. Between any two consecutive register states, the block emits three blended vectors. In each blended vector, every bit comes from either the present state or the next state. Each input of the circuit under test therefore changes at most once while the output walks from one major vector to the next. The transitions that would have landed in one cycle are spread over four cycles.

The shift register moves to its next state once every four enabled cycles. A two-bit sub-step counter selects what appears on the output: the major vector first, then the three blends in order. The counter value is brought out so that a response collector can tell which sub-step is being applied. A seed can be loaded at any time. Releasing the enable freezes the whole sequence.

Top module: `lowtrans_tpg`

## Requirements
- R1: After synchronous reset, `pattern_o` equals the default seed 36'b010010100101101011010010100101101011 (MSB first), and `substep_o` is 0.
- R2: At each major step, the register state S becomes {S[34:0], S[35]^S[10]}, which corresponds to the polynomial x^36+x^11+1. The major vectors shown at sub-step 0 follow this sequence exactly.
- R3: While `en_i`=1 and `load_i`=0, `substep_o` counts 0,1,2,3,0 with one step per cycle. The register advances only on the cycle where the count wraps from 3 to 0.
- R4: At sub-step 0, `pattern_o` equals the present state P. At sub-step 1, every bit i with i mod 4 = 0 takes the next-state value N[i], and all other bits take P[i].
- R5: At sub-step 2, bits with i mod 4 in {0,1} take N[i]. At sub-step 3, bits with i mod 4 in {0,1,2} take N[i]. All remaining bits take P[i].
- R6: Over the five-vector window from one major vector to the next, no output bit toggles more than once. The total number of toggles equals the Hamming distance between the two major vectors.
- R7: While `en_i`=0 and `load_i`=0, `pattern_o` and `substep_o` hold their values.
- R8: When `load_i`=1, the next cycle shows `pattern_o` = `seed_i` and `substep_o` = 0, whatever the values of `en_i` and the sub-step. Load takes priority over advancing.
- R9: Starting from a non-zero state, the register never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance enable |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 36 | Seed value to load |
| pattern_o | output | 36 | Vector applied to the circuit under test |
| substep_o | output | 2 | Sub-step currently on the output (0 = major vector) |

## Verification
The assertions assume that every seed loaded through `seed_i` is non-zero. An all-zero register would lock the sequence and break the non-zero and transition checks. The stimulus loads only non-zero seeds, in three cases: mid-window with enable high, with enable low, and at the wrap sub-step. Between loads, it runs long enabled stretches and enable-low pauses. The bench starts each transition window at sub-step 0, so every window it measures is complete.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;

    localparam int unsigned DEF_WIDTH = 36;
    localparam int unsigned DEF_TAP   = 10;
    localparam logic [DEF_WIDTH-1:0] DEF_SEED =
        36'b010010100101101011010010100101101011;

    typedef enum logic [1:0] {
        PH_BASE = 2'd0,
        PH_A    = 2'd1,
        PH_B    = 2'd2,
        PH_C    = 2'd3
    } phase_e;

    typedef struct packed {
        logic load;
        logic advance;
    } ctl_t;

    // Bit group of position idx: a bit takes its next-state value
    // once the sub-step exceeds its group number.
    function automatic logic [1:0] bit_group(input int unsigned idx);
        return 2'(idx % 4);
    endfunction

endpackage

// File: rtl/ltpg_ctrl.sv
module ltpg_ctrl
    import ltpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       load_i,
    output logic [1:0] phase_o,
    output ctl_t       ctl_o
);

    logic [1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_BASE;
        end else if (load_i) begin
            ph_q <= PH_BASE;
        end else if (en_i) begin
            ph_q <= ph_q + 2'd1;
        end
    end

    always_comb begin
        ctl_o.load    = load_i;
        ctl_o.advance = en_i && !load_i && (ph_q == PH_C);
    end

    assign phase_o = ph_q;

    // R3: sub-step counts up by one on each enabled cycle
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (en_i && !load_i) |=> ph_q == $past(ph_q) + 2'd1);

    // R7: sub-step frozen while disabled
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(ph_q));

    // R8: load returns the sub-step to the major vector
    a_r8_load_phase: assert property (@(posedge clk) disable iff (rst)
        load_i |=> ph_q == 2'd0);

endmodule

// File: rtl/ltpg_lfsr_core.sv
module ltpg_lfsr_core
    import ltpg_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned TAP   = DEF_TAP,
    parameter logic [WIDTH-1:0] SEED = DEF_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] nxt_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] state_q;
    logic             fb;

    assign fb    = state_q[MSB] ^ state_q[TAP];
    assign nxt_o = {state_q[MSB-1:0], fb};
    assign cur_o = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (ctl_i.load) begin
            state_q <= seed_i;
        end else if (ctl_i.advance) begin
            state_q <= nxt_o;
        end
    end

    // R3: register holds between major steps
    a_r3_mid_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.load && !ctl_i.advance) |=> $stable(state_q));

    // R2: a major step shifts the register towards the MSB
    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        ctl_i.advance |=> state_q[MSB:1] == $past(state_q[MSB-1:0]));

    // R8: loaded seed lands in the register
    a_r8_seed: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> state_q == $past(seed_i));

    // R9: register never reaches all zeros (non-zero seeds assumed)
    a_r9_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/ltpg_interp_mux.sv
module ltpg_interp_mux
    import ltpg_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] nxt_i,
    input  logic [1:0]       phase_i,
    output logic [WIDTH-1:0] pattern_o
);

    logic [WIDTH-1:0] take_nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam logic [1:0] GRP = bit_group(i);
        assign take_nxt[i]  = phase_i > GRP;
        assign pattern_o[i] = take_nxt[i] ? nxt_i[i] : cur_i[i];
    end

    // R6: bits equal in both states never move inside the window
    a_r6_between: assert property (@(posedge clk) disable iff (rst)
        (pattern_o & ~(cur_i ^ nxt_i)) == (cur_i & ~(cur_i ^ nxt_i)));

    // R4: sub-step 0 shows the present state untouched
    a_r4_base: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_BASE) |-> pattern_o == cur_i);

endmodule

// File: rtl/lowtrans_tpg.sv
module lowtrans_tpg
    import ltpg_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned TAP   = DEF_TAP,
    parameter logic [WIDTH-1:0] SEED = DEF_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic [1:0]       substep_o
);

    ctl_t             ctl;
    logic [1:0]       phase;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    ltpg_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .load_i  (load_i),
        .phase_o (phase),
        .ctl_o   (ctl)
    );

    ltpg_lfsr_core #(
        .WIDTH (WIDTH),
        .TAP   (TAP),
        .SEED  (SEED)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .seed_i (seed_i),
        .cur_o  (cur),
        .nxt_o  (nxt)
    );

    ltpg_interp_mux #(
        .WIDTH (WIDTH)
    ) u_mux (
        .clk       (clk),
        .rst       (rst),
        .cur_i     (cur),
        .nxt_i     (nxt),
        .phase_i   (phase),
        .pattern_o (pattern_o)
    );

    assign substep_o = phase;

    // R7: output vector frozen while disabled
    a_r7_pattern_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(pattern_o));

endmodule

// File: tb/test_lowtrans_tpg.sv
module test_lowtrans_tpg;

    localparam int W = 36;
    localparam logic [W-1:0] RST_SEED = 36'b010010100101101011010010100101101011;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] seed_i = '0;
    logic [W-1:0] pattern_o;
    logic [1:0]   substep_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [W-1:0] m_state;
    int           m_phase;

    lowtrans_tpg i_lowtrans_tpg (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .load_i    (load_i),
        .seed_i    (seed_i),
        .pattern_o (pattern_o),
        .substep_o (substep_o)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] s);
        return {s[W-2:0], s[35] ^ s[10]};
    endfunction

    function automatic logic [W-1:0] ref_pat(input logic [W-1:0] s, input int ph);
        logic [W-1:0] n = ref_next(s);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = ((i % 4) < ph) ? n[i] : s[i];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check({req, " substep"}, W'(substep_o), W'(m_phase));
        check({req, " pattern"}, pattern_o, ref_pat(m_state, m_phase));
    endtask

    task automatic model_step();
        if (m_phase == 3) begin
            m_state = ref_next(m_state);
            m_phase = 0;
        end else begin
            m_phase++;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        check("R1 reset pattern", pattern_o, RST_SEED);
        check("R1 reset substep", W'(substep_o), '0);
        m_state = RST_SEED;
        m_phase = 0;
    endtask

    // R2 R3 R4 R5 R6 R9: enabled run, per-cycle model and per-window toggle checks
    task automatic t_walk(input int windows);
        logic [W-1:0] prev, wstart, seen, twice, diff;
        int ntog;
        en_i = 1'b1;
        wstart = pattern_o;
        seen = '0;
        twice = '0;
        ntog = 0;
        for (int c = 0; c < windows * 4; c++) begin
            prev = pattern_o;
            tick();
            model_step();
            check_model("R2/R3/R4/R5 walk");
            diff = prev ^ pattern_o;
            twice |= seen & diff;
            seen |= diff;
            ntog += $countones(diff);
            if (m_phase == 0) begin
                check("R6 single toggle per bit", twice, '0);
                check("R6 toggle total", W'(ntog), W'($countones(wstart ^ pattern_o)));
                check("R9 nonzero", W'(pattern_o == '0), '0);
                wstart = pattern_o;
                seen = '0;
                twice = '0;
                ntog = 0;
            end
        end
        en_i = 1'b0;
    endtask

    // R7: enable low freezes everything mid-window
    task automatic t_hold();
        logic [W-1:0] held_p;
        logic [1:0]   held_s;
        en_i = 1'b1;
        tick(); model_step();
        tick(); model_step();
        en_i = 1'b0;
        held_p = pattern_o;
        held_s = substep_o;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R7 hold pattern", pattern_o, held_p);
            check("R7 hold substep", W'(substep_o), W'(held_s));
        end
        en_i = 1'b1;
        tick(); model_step();
        check_model("R7 resume");
        tick(); model_step();
        check_model("R7 resume wrap");
        en_i = 1'b0;
    endtask

    // R8: load priority over enable and over the wrap step
    task automatic t_load();
        en_i = 1'b1;
        tick(); model_step();
        load_i = 1'b1;
        seed_i = 36'h123456789;
        tick();
        load_i = 1'b0;
        en_i = 1'b0;
        check("R8 load while enabled pattern", pattern_o, 36'h123456789);
        check("R8 load while enabled substep", W'(substep_o), '0);
        m_state = 36'h123456789;
        m_phase = 0;

        load_i = 1'b1;
        seed_i = 36'hF0F0F0F0F;
        tick();
        load_i = 1'b0;
        check("R8 load while disabled pattern", pattern_o, 36'hF0F0F0F0F);
        check("R8 load while disabled substep", W'(substep_o), '0);
        m_state = 36'hF0F0F0F0F;

        en_i = 1'b1;
        for (int k = 0; k < 3; k++) begin tick(); model_step(); end
        check("R8 reached wrap substep", W'(substep_o), W'(3));
        load_i = 1'b1;
        seed_i = 36'h800000001;
        tick();
        load_i = 1'b0;
        en_i = 1'b0;
        check("R8 load beats wrap pattern", pattern_o, 36'h800000001);
        check("R8 load beats wrap substep", W'(substep_o), '0);
        m_state = 36'h800000001;
        m_phase = 0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_walk(600);
        t_hold();
        t_walk(50);
        t_load();
        t_walk(400);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule